// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block moves bytes between two buses, called side A and side B, in either direction. Each side feeds its own holding register, and each register has its own capture clock. For each direction a select input decides what the receiving bus gets: the live value on the other bus, or the value held in that direction's register. An active-low enable and a direction input decide which bus, if either, is driven.

The buses are modelled without tri-state pads. Each side has a separate input vector, an output vector and a single output-enable bit. A pad ring or bus fabric outside the block combines them. The output vectors always carry the selected value, and the enable bit says whether that value may reach the wire. A build parameter makes both data paths invert their data.

The registers capture on every rising edge of their clocks, whatever the enable, direction and select inputs are. This lets the block sample one bus while it drives the other, or while it drives neither. In stored mode the byte captured on an edge reaches the opposite output in the same operation.

Top module: `xfer_bridge`

## Requirements
- R1: An active-low asynchronous reset (`rst_n` low) clears both holding registers to all zeros. After reset, a direction in stored mode outputs zero, or all ones when `INVERT` is 1.
- R2: On every rising edge of `clk_a`, the A-side register loads `a_in`, whatever the values of `en_n`, `dir_a2b`, `a2b_sel_stored` and `b2a_sel_stored`.
- R3: On every rising edge of `clk_b`, the B-side register loads `b_in`, whatever the values of the control inputs.
- R4: While `en_n` is 1 (isolation), `a_oe` and `b_oe` are both 0, and both registers keep loading as R2 and R3 state.
- R5: While `en_n` is 0 and `dir_a2b` is 1, `b_oe` is 1 and `a_oe` is 0.
- R6: While `en_n` is 0 and `dir_a2b` is 0, `a_oe` is 1 and `b_oe` is 0. The two enables are never 1 together.
- R7: While `a2b_sel_stored` is 0, `b_out` follows the live `a_in`, with no clock involved.
- R8: While `a2b_sel_stored` is 1, `b_out` shows the A-side register.
- R9: `b2a_sel_stored` controls `a_out` in the same way: 0 gives the live `b_in`, 1 gives the B-side register.
- R10: In stored mode, the byte captured on a capture-clock edge appears at the opposite output right after that edge.
- R11: With `INVERT` = 1, `a_out` and `b_out` are the bitwise complement of the selected data. With `INVERT` = 0 they equal it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Capture clock of the A-side register |
| clk_b | input | 1 | Capture clock of the B-side register |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_n | input | 1 | Output enable, active low; 1 isolates both buses |
| dir_a2b | input | 1 | 1 drives bus B from the A path; 0 drives bus A from the B path |
| a2b_sel_stored | input | 1 | A-to-B source: 0 live `a_in`, 1 A-side register |
| b2a_sel_stored | input | 1 | B-to-A source: 0 live `b_in`, 1 B-side register |
| a_in | input | W | Value currently on bus A |
| b_in | input | W | Value currently on bus B |
| a_out | output | W | Value offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | W | Value offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The hardest case to reach from the ports is a capture made while both outputs are isolated. Its effect is invisible at the moment it happens. It shows only later, once a direction is enabled in stored mode. The stimulus walks every combination of enable, direction and the two selects, four times over. Each pass changes which capture clocks pulse, so bytes stored during isolation are read out by later stored-mode steps. A second instance built with `INVERT` = 1 receives the same stimulus, which covers the complemented path.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int unsigned XFER_W = 8;

    // Decoded drive enables for the two bus sides.
    typedef struct packed {
        logic a_drv;
        logic b_drv;
    } drive_t;

endpackage

// File: rtl/xfer_store.sv
module xfer_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] data;
    } store_t;

    store_t st_d, st_q;

    // Capture on every edge: the output controls never gate loading.
    always_comb begin
        st_d      = st_q;
        st_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.data;
endmodule

// File: rtl/xfer_path.sv
module xfer_path #(
    parameter int unsigned W      = 8,
    parameter bit          INVERT = 1'b0
) (
    input  logic         use_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] dout
);
    logic [W-1:0] pick_d;

    always_comb begin
        pick_d = use_stored ? stored : live;
    end

    generate
        if (INVERT) begin : g_inv
            assign dout = ~pick_d;
        end else begin : g_pass
            assign dout = pick_d;
        end
    endgenerate
endmodule

// File: rtl/xfer_drive_ctl.sv
module xfer_drive_ctl
    import xfer_pkg::*;
(
    input  logic   en_n,
    input  logic   dir_a2b,
    output drive_t drv
);
    drive_t drv_d;

    always_comb begin
        drv_d       = '0;
        if (!en_n) begin
            drv_d.b_drv = dir_a2b;
            drv_d.a_drv = ~dir_a2b;
        end
    end

    assign drv = drv_d;
endmodule

// File: rtl/xfer_bridge.sv
module xfer_bridge
    import xfer_pkg::*;
#(
    parameter int unsigned W      = XFER_W,
    parameter bit          INVERT = 1'b0
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         en_n,
    input  logic         dir_a2b,
    input  logic         a2b_sel_stored,
    input  logic         b2a_sel_stored,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [W-1:0] held_a;
    logic [W-1:0] held_b;
    drive_t       drv;

    xfer_store #(.W(W)) u_hold_a (
        .clk(clk_a), .rst_n(rst_n), .din(a_in), .q(held_a)
    );

    xfer_store #(.W(W)) u_hold_b (
        .clk(clk_b), .rst_n(rst_n), .din(b_in), .q(held_b)
    );

    xfer_path #(.W(W), .INVERT(INVERT)) u_path_a2b (
        .use_stored(a2b_sel_stored), .live(a_in), .stored(held_a), .dout(b_out)
    );

    xfer_path #(.W(W), .INVERT(INVERT)) u_path_b2a (
        .use_stored(b2a_sel_stored), .live(b_in), .stored(held_b), .dout(a_out)
    );

    xfer_drive_ctl u_drive (
        .en_n(en_n), .dir_a2b(dir_a2b), .drv(drv)
    );

    assign a_oe = drv.a_drv;
    assign b_oe = drv.b_drv;
endmodule

// File: rtl/xfer_bridge_chk.sv
module xfer_bridge_chk #(
    parameter int unsigned W      = 8,
    parameter bit          INVERT = 1'b0
) (
    input logic         clk_a,
    input logic         clk_b,
    input logic         rst_n,
    input logic         en_n,
    input logic         dir_a2b,
    input logic         a2b_sel_stored,
    input logic         b2a_sel_stored,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic [W-1:0] held_a,
    input logic [W-1:0] held_b
);
    localparam logic [W-1:0] FLIP = INVERT ? {W{1'b1}} : '0;

    a_r2_capture_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        rst_n |=> (held_a == $past(a_in)));

    a_r3_capture_b: assert property (@(posedge clk_b) disable iff (!rst_n)
        rst_n |=> (held_b == $past(b_in)));

    a_r4_isolate: assert property (@(posedge clk_a) disable iff (!rst_n)
        en_n |-> (!a_oe && !b_oe));

    a_r5_b_side: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!en_n && dir_a2b) |-> (b_oe && !a_oe));

    a_r6_exclusive: assert property (@(posedge clk_a) disable iff (!rst_n)
        !en_n |-> $onehot0({a_oe, b_oe}) && (a_oe != b_oe));

    a_r8_stored_a2b: assert property (@(posedge clk_a) disable iff (!rst_n)
        a2b_sel_stored |-> (b_out == (held_a ^ FLIP)));

    a_r7_live_a2b: assert property (@(posedge clk_b) disable iff (!rst_n)
        !a2b_sel_stored |-> (b_out == (a_in ^ FLIP)));

    a_r9_stored_b2a: assert property (@(posedge clk_b) disable iff (!rst_n)
        b2a_sel_stored |-> (a_out == (held_b ^ FLIP)));
endmodule

bind xfer_bridge xfer_bridge_chk #(.W(W), .INVERT(INVERT)) u_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .en_n(en_n),
    .dir_a2b(dir_a2b), .a2b_sel_stored(a2b_sel_stored),
    .b2a_sel_stored(b2a_sel_stored), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .held_a(held_a), .held_b(held_b)
);

// File: tb/xfer_bridge_bench.sv
module xfer_bridge_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic       en_n = 1'b1, dir_a2b = 1'b0, sab = 1'b0, sba = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic [7:0] a_out, b_out, ia_out, ib_out;
    logic       a_oe, b_oe, ia_oe, ib_oe;

    int total = 0;
    int bad   = 0;
    logic [7:0] m_ra = '0, m_rb = '0;

    xfer_bridge #(.W(8), .INVERT(1'b0)) u_xfer_bridge (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .en_n(en_n),
        .dir_a2b(dir_a2b), .a2b_sel_stored(sab), .b2a_sel_stored(sba),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe)
    );

    xfer_bridge #(.W(8), .INVERT(1'b1)) u_xfer_bridge_inv (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .en_n(en_n),
        .dir_a2b(dir_a2b), .a2b_sel_stored(sab), .b2a_sel_stored(sba),
        .a_in(a_in), .b_in(b_in), .a_out(ia_out), .a_oe(ia_oe),
        .b_out(ib_out), .b_oe(ib_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output of both instances against the behavioural model.
    task automatic compare(input bit pa, input bit pb);
        logic [7:0] exp_b, exp_a;
        logic       exp_aoe, exp_boe;
        exp_b   = sab ? m_ra : a_in;
        exp_a   = sba ? m_rb : b_in;
        exp_boe = !en_n && dir_a2b;
        exp_aoe = !en_n && !dir_a2b;
        if (en_n) begin
            chk("R4 a_oe isolated", {7'd0, a_oe}, 8'd0);
            chk("R4 b_oe isolated", {7'd0, b_oe}, 8'd0);
        end else if (dir_a2b) begin
            chk("R5 b_oe", {7'd0, b_oe}, {7'd0, exp_boe});
            chk("R5 a_oe", {7'd0, a_oe}, {7'd0, exp_aoe});
        end else begin
            chk("R6 a_oe", {7'd0, a_oe}, {7'd0, exp_aoe});
            chk("R6 b_oe", {7'd0, b_oe}, {7'd0, exp_boe});
        end
        if (!sab)    chk("R7 live b_out", b_out, exp_b);
        else if (pa) chk("R10 R2 capture to b_out", b_out, exp_b);
        else         chk("R8 R2 stored b_out", b_out, exp_b);
        if (!sba)    chk("R9 live a_out", a_out, exp_a);
        else if (pb) chk("R10 R3 capture to a_out", a_out, exp_a);
        else         chk("R9 R3 stored a_out", a_out, exp_a);
        chk("R11 inverted b_out", ib_out, ~exp_b);
        chk("R11 inverted a_out", ia_out, ~exp_a);
        chk("R11 inv oe", {6'd0, ia_oe, ib_oe}, {6'd0, exp_aoe, exp_boe});
    endtask

    task automatic step(input logic e, input logic d, input logic s1, input logic s2,
                        input logic [7:0] a, input logic [7:0] b,
                        input bit pa, input bit pb);
        @(negedge clk);
        en_n = e; dir_a2b = d; sab = s1; sba = s2; a_in = a; b_in = b;
        #1;
        if (pa) begin clk_a = 1'b1; m_ra = a; end
        if (pb) begin clk_b = 1'b1; m_rb = b; end
        #1;
        clk_a = 1'b0; clk_b = 1'b0;
        #1;
        compare(pa, pb);
    endtask

    initial begin : watchdog
        #1000000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: registers read as zero (or all ones inverted) during reset.
        en_n = 1'b0; dir_a2b = 1'b1; sab = 1'b1; sba = 1'b1;
        a_in = 8'h5a; b_in = 8'hc3;
        #1;
        chk("R1 reset b_out", b_out, 8'h00);
        chk("R1 reset a_out", a_out, 8'h00);
        chk("R1 reset inv b_out", ib_out, 8'hff);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 8'h22, 1'b0, 1'b0);
        chk("R1 after release b_out", b_out, 8'h00);

        // R4: capture while isolated, then read back in stored mode.
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'ha5, 8'h3c, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hff, 1'b0, 1'b0);
        chk("R4 R2 isolated capture on b_out", b_out, 8'ha5);
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'hff, 8'h00, 1'b0, 1'b0);
        chk("R4 R3 isolated capture on a_out", a_out, 8'h3c);

        // Walk every control combination with varied capture pulses.
        for (int rep = 0; rep < 4; rep++) begin
            for (int c = 0; c < 16; c++) begin
                step(c[3], c[2], c[1], c[0], 8'($urandom), 8'($urandom),
                     rep[0], rep[1]);
                step(c[3], c[2], c[1], c[0], 8'($urandom), 8'($urandom),
                     1'b0, 1'b0);
            end
        end

        // Edge values through both paths.
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'hff, 8'h00, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hff, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h80, 8'h01, 1'b1, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule